// File: doc/BRIEF.md
# Memory Page Access Protection Checker

This block stands between the requesters of a banked on-chip memory and the memory itself. Each request carries an address, a read/write flag, a three-bit requester identity and a flag marking whether it arrives straight from the local processor or from a system master or DMA engine. The upper address bits pick one of the memory pages. Each page holds a permission word with one enable bit per requester identity and one local bit. Together with the request's origin, these bits decide whether the request is forwarded or blocked.

A blocked request never reaches the memory, but it still completes with a response, so no requester waits. A blocked read returns zero. The first violation is recorded in a fault status word, which holds the requester identity, the address and the direction. A one-cycle event goes toward the interrupt controller. Later violations only set a sticky overflow flag. Software reads the permissions and the fault record through a small register port, and clears the record by writing to it.

Allowed and blocked requests take the same number of cycles. The request is registered once before it is presented to the memory. The response returns one cycle after that, which matches a memory with one cycle of read latency.

Top module: `mpp_guard`

## Requirements
- R1: After reset every page permission word reads 0x7F, so all pages are fully open. The fault status word reads 0, and mem_en, fault_evt and rsp_valid are low.
- R2: A request with req_direct=1 is allowed exactly when bit 6 (the local bit) of its page's permission word is 1. The identity enable bits play no part in this decision.
- R3: A request with req_direct=0 is allowed exactly when bit req_id (0 to 5) of its page's permission word is 1. Identities 6 and 7 are always denied.
- R4: A request accepted at clock edge E is shown to the memory after E, with mem_en high only if it is allowed and mem_we high only if it is also a write. rsp_valid is high for one cycle after edge E+1. For an allowed read, rsp_rdata carries mem_rdata.
- R5: A denied request keeps the same response timing. A denied read gives rsp_rdata=0. A denied write drives neither mem_en nor mem_we, so the stored word stays unchanged.
- R6: A violation with no record pending sets the fault status word as follows: bit0 = valid, bit1 = overflow, bit2 = 1 for a write, bits 6:4 = requester identity, bits 31:16 = request address.
- R7: fault_evt is high for exactly the one cycle after the edge that accepted a violating request. It stays low for allowed requests.
- R8: A violation that arrives while the record is valid leaves the captured identity, address and direction unchanged, and sets the overflow bit.
- R9: A register write to index 16 with data bit 0 set clears the valid and overflow bits. If a violation is accepted on the same edge, the new violation is captured with overflow 0.
- R10: A register write to index p (0 to 15) sets page p's permission word from data bits 6:0. Requests accepted after that edge use the new word. Register reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; the top PAGE_W bits select the page |
| req_wdata | input | DATA_W | Write data |
| req_id | input | 3 | Requester identity |
| req_direct | input | 1 | 1 = direct processor access, 0 = system master or DMA |
| rsp_valid | output | 1 | Response for the request two edges earlier |
| rsp_rdata | output | DATA_W | Read data, zero when denied |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_en |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | PAGE_W+1 | Register index: pages 0..15, fault status at 16 |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| fault_evt | output | 1 | One-cycle violation event |

## Verification
The bench builds the block with ADDR_W=10, PAGE_W=4 and DATA_W=32. This gives sixteen pages of 64 words, and the bench's memory model covers the whole 1024-word space. Every permission combination can then be written, and the stored word can be read back after a blocked write. With a 10-bit address, the upper status bits must read as zero and the page field sits below them, so an address shifted into the wrong place shows up in the record. Same-edge cases are driven directly: a clear together with a violation, and a second violation while a record is held.

// File: rtl/mpp_pkg.sv
package mpp_pkg;
  localparam int MPP_IDS  = 6;
  localparam int MPP_ID_W = 3;
  localparam int MPP_REC_AW = 16;

  typedef struct packed {
    logic               lcl;
    logic [MPP_IDS-1:0] aid;
  } page_perm_t;

  typedef struct packed {
    logic                  wr;
    logic [MPP_ID_W-1:0]   id;
    logic [MPP_REC_AW-1:0] addr;
  } fault_rec_t;

  localparam page_perm_t PERM_OPEN = '{lcl: 1'b1, aid: '1};
endpackage

// File: rtl/mpp_perm_file.sv
module mpp_perm_file
  import mpp_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  page_perm_t        wr_val,
  input  logic [PAGE_W-1:0] cfg_page,
  output page_perm_t        cfg_val,
  input  logic [PAGE_W-1:0] chk_page,
  output page_perm_t        chk_val
);
  localparam int NPAGE = 1 << PAGE_W;

  page_perm_t perm_q [NPAGE];

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    logic       ld;
    page_perm_t nxt;
    always_comb begin
      ld  = wr_en && (wr_page == PAGE_W'(p));
      nxt = ld ? wr_val : perm_q[p];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) perm_q[p] <= PERM_OPEN;
      else if (ld) perm_q[p] <= nxt;
    end
  end

  assign cfg_val = perm_q[cfg_page];
  assign chk_val = perm_q[chk_page];
endmodule

// File: rtl/mpp_rule.sv
module mpp_rule
  import mpp_pkg::*;
(
  input  page_perm_t          perm,
  input  logic [MPP_ID_W-1:0] id,
  input  logic                direct,
  output logic                allow
);
  logic aid_bit;

  always_comb begin
    aid_bit = 1'b0;
    for (int i = 0; i < MPP_IDS; i++) begin
      if (id == MPP_ID_W'(i)) aid_bit = perm.aid[i];
    end
    allow = direct ? perm.lcl : aid_bit;
  end
endmodule

// File: rtl/mpp_fault_log.sv
module mpp_fault_log
  import mpp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       viol,
  input  fault_rec_t rec_in,
  input  logic       clr,
  output logic       evt,
  output logic       valid,
  output logic       ovf,
  output fault_rec_t rec
);
  logic       valid_n, ovf_n, evt_n, rec_ld;
  fault_rec_t rec_n;

  always_comb begin
    valid_n = valid;
    ovf_n   = ovf;
    rec_ld  = 1'b0;
    evt_n   = viol;
    if (viol) begin
      if (valid && !clr) begin
        ovf_n = 1'b1;
      end else begin
        rec_ld  = 1'b1;
        valid_n = 1'b1;
        ovf_n   = 1'b0;
      end
    end else if (clr) begin
      valid_n = 1'b0;
      ovf_n   = 1'b0;
    end
    rec_n = rec_ld ? rec_in : rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      ovf   <= 1'b0;
      evt   <= 1'b0;
      rec   <= '0;
    end else begin
      valid <= valid_n;
      ovf   <= ovf_n;
      evt   <= evt_n;
      if (rec_ld) rec <= rec_n;
    end
  end

  // R7
  evt_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> valid);
  // R8
  ovf_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> valid);
  // R8
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clr) |=> $stable(rec));
endmodule

// File: rtl/mpp_guard.sv
module mpp_guard
  import mpp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [2:0]          req_id,
  input  logic                req_direct,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                cfg_wr,
  input  logic [PAGE_W:0]     cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                fault_evt
);
  localparam int NPAGE = 1 << PAGE_W;
  localparam logic [PAGE_W:0] STAT_IDX = (PAGE_W+1)'(NPAGE);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // permission storage
  page_perm_t  cfg_perm, chk_perm, wr_perm;
  logic        perm_wr;
  logic [PAGE_W-1:0] chk_page;

  assign perm_wr  = cfg_wr && !cfg_addr[PAGE_W];
  assign wr_perm  = page_perm_t'(cfg_wdata[MPP_IDS:0]);
  assign chk_page = req_addr[ADDR_W-1 -: PAGE_W];

  mpp_perm_file #(.PAGE_W(PAGE_W)) u_perm (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (perm_wr),
    .wr_page  (cfg_addr[PAGE_W-1:0]),
    .wr_val   (wr_perm),
    .cfg_page (cfg_addr[PAGE_W-1:0]),
    .cfg_val  (cfg_perm),
    .chk_page (chk_page),
    .chk_val  (chk_perm)
  );

  logic allow;
  mpp_rule u_rule (
    .perm   (chk_perm),
    .id     (req_id),
    .direct (req_direct),
    .allow  (allow)
  );

  // fault capture
  logic       viol, clr, f_valid, f_ovf;
  fault_rec_t rec_in, f_rec;

  assign viol   = req_valid && !allow;
  assign clr    = cfg_wr && (cfg_addr == STAT_IDX) && cfg_wdata[0];
  assign rec_in = '{wr: req_we, id: req_id, addr: MPP_REC_AW'(req_addr)};

  mpp_fault_log u_log (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .viol   (viol),
    .rec_in (rec_in),
    .clr    (clr),
    .evt    (fault_evt),
    .valid  (f_valid),
    .ovf    (f_ovf),
    .rec    (f_rec)
  );

  // stage 1: present to memory
  logic              s1_en_n, s1_we_n, s1_v_n, s1_rd_n;
  logic              s1_v_q, s1_rd_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [DATA_W-1:0] s1_wdata_q;
  logic              s1_en_q, s1_we_q;

  always_comb begin
    s1_v_n  = req_valid;
    s1_en_n = req_valid && allow;
    s1_we_n = req_valid && allow && req_we;
    s1_rd_n = req_valid && allow && !req_we;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_v_q  <= 1'b0;
      s1_en_q <= 1'b0;
      s1_we_q <= 1'b0;
      s1_rd_q <= 1'b0;
    end else begin
      s1_v_q  <= s1_v_n;
      s1_en_q <= s1_en_n;
      s1_we_q <= s1_we_n;
      s1_rd_q <= s1_rd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_addr_q  <= '0;
      s1_wdata_q <= '0;
    end else if (req_valid) begin
      s1_addr_q  <= req_addr;
      s1_wdata_q <= req_wdata;
    end
  end

  assign mem_en    = s1_en_q;
  assign mem_we    = s1_we_q;
  assign mem_addr  = s1_addr_q;
  assign mem_wdata = s1_wdata_q;

  // stage 2: response
  logic s2_v_q, s2_rd_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s2_v_q  <= 1'b0;
      s2_rd_q <= 1'b0;
    end else begin
      s2_v_q  <= s1_v_q;
      s2_rd_q <= s1_rd_q;
    end
  end

  assign rsp_valid = s2_v_q;
  assign rsp_rdata = s2_rd_q ? mem_rdata : '0;

  // register read
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == STAT_IDX)
      cfg_rdata = {f_rec.addr, 9'd0, f_rec.id, 1'b0, f_rec.wr, f_ovf, f_valid};
    else if (!cfg_addr[PAGE_W])
      cfg_rdata = 32'(cfg_perm);
  end

  // R4
  fwd_or_fault_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(mem_en && fault_evt));
  // R4
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_en |=> rsp_valid);
  // R5
  we_within_en_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |-> mem_en);
  // R7
  evt_has_rsp_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    fault_evt |=> rsp_valid);
endmodule

// File: tb/mpp_guard_test.sv
`timescale 1ns/1ps
module mpp_guard_test;
  localparam int AW = 10;
  localparam int PW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_we, req_direct;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [2:0]    req_id;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          cfg_wr;
  logic [PW:0]   cfg_addr;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic          fault_evt;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  mpp_guard #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_id(req_id), .req_direct(req_direct),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .fault_evt(fault_evt)
  );

  // memory model, one cycle read latency
  logic [DW-1:0] mem [1 << AW];
  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(input logic wr, input logic [2:0] id,
                                       input logic [AW-1:0] a, input logic ov);
    return {16'(a), 9'd0, id, 1'b0, wr, ov, 1'b1};
  endfunction

  task automatic cfg_write(input logic [PW:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [PW:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // issue one request, capture port results
  task automatic do_req(input logic [2:0] id, input logic dir, input logic we,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic en, output logic evt, output logic rv,
                        output logic [DW-1:0] rd, output logic evt2);
    @(negedge clk);
    req_valid = 1'b1; req_id = id; req_direct = dir; req_we = we;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    en = mem_en; evt = fault_evt;
    @(negedge clk);
    rv = rsp_valid; rd = rsp_rdata; evt2 = fault_evt;
  endtask

  logic en, evt, rv, evt2;
  logic [31:0] rd, r;

  task automatic t_reset();
    for (int p = 0; p < 16; p++) begin
      cfg_read(5'(p), r);
      check("R1 perm open", r, 32'h7F);
    end
    cfg_read(5'd16, r);
    check("R1 status", r, 0);
    check("R1 outputs", {29'd0, mem_en, fault_evt, rsp_valid}, 0);
  endtask

  task automatic t_open();
    do_req(3'd3, 1'b0, 1'b1, 10'h005, 32'hA5A5_0001, en, evt, rv, rd, evt2);
    check("R4 write en", {31'd0, en}, 1);
    check("R4 write no evt", {31'd0, evt}, 0);
    do_req(3'd0, 1'b1, 1'b0, 10'h005, 0, en, evt, rv, rd, evt2);
    check("R4 read rsp_valid", {31'd0, rv}, 1);
    check("R4 read data", rd, 32'hA5A5_0001);
  endtask

  task automatic t_deny_all();
    // page 1 (addr 0x040..0x07F): seed a word, then close page
    do_req(3'd1, 1'b1, 1'b1, 10'h045, 32'h1234_5678, en, evt, rv, rd, evt2);
    cfg_write(5'd1, 32'h00);
    cfg_read(5'd1, r);
    check("R10 perm readback", r, 0);
    do_req(3'd1, 1'b1, 1'b0, 10'h045, 0, en, evt, rv, rd, evt2);
    check("R2 direct denied en", {31'd0, en}, 0);
    check("R5 denied read rsp_valid", {31'd0, rv}, 1);
    check("R5 denied read zero", rd, 0);
    check("R7 evt pulse", {30'd0, evt, evt2}, 32'b10);
    cfg_read(5'd16, r);
    check("R6 record", r, stat(1'b0, 3'd1, 10'h045, 1'b0));
    do_req(3'd4, 1'b0, 1'b1, 10'h045, 32'hDEAD_BEEF, en, evt, rv, rd, evt2);
    check("R5 denied write en", {31'd0, en}, 0);
    check("R7 second evt", {31'd0, evt}, 1);
    cfg_read(5'd16, r);
    check("R8 first kept + ovf", r, stat(1'b0, 3'd1, 10'h045, 1'b1));
    cfg_write(5'd16, 32'h1);
    cfg_read(5'd16, r);
    check("R9 cleared", r[1:0], 0);
    cfg_write(5'd1, 32'h7F);
    do_req(3'd0, 1'b1, 1'b0, 10'h045, 0, en, evt, rv, rd, evt2);
    check("R5 word unchanged", rd, 32'h1234_5678);
  endtask

  task automatic t_local_only();
    cfg_write(5'd2, 32'h40);  // page 2: local only
    do_req(3'd2, 1'b1, 1'b0, 10'h080, 0, en, evt, rv, rd, evt2);
    check("R2 direct allowed", {31'd0, en}, 1);
    do_req(3'd2, 1'b0, 1'b0, 10'h080, 0, en, evt, rv, rd, evt2);
    check("R3 nondirect denied aid0", {31'd0, en}, 0);
    cfg_read(5'd16, r);
    check("R6 nondirect record", r, stat(1'b0, 3'd2, 10'h080, 1'b0));
    cfg_write(5'd16, 32'h1);
  endtask

  task automatic t_aid_only();
    cfg_write(5'd3, 32'h10);  // page 3: only id 4, local 0
    do_req(3'd4, 1'b0, 1'b1, 10'h0C1, 32'h77, en, evt, rv, rd, evt2);
    check("R3 id4 allowed", {31'd0, en}, 1);
    do_req(3'd3, 1'b0, 1'b1, 10'h0C1, 32'h77, en, evt, rv, rd, evt2);
    check("R3 id3 denied", {31'd0, en}, 0);
    do_req(3'd4, 1'b1, 1'b0, 10'h0C1, 0, en, evt, rv, rd, evt2);
    check("R2 direct denied local0", {31'd0, en}, 0);
    cfg_read(5'd16, r);
    check("R6 write record kept, ovf", r, stat(1'b1, 3'd3, 10'h0C1, 1'b1));
    cfg_write(5'd16, 32'h1);
  endtask

  task automatic t_bad_id();
    cfg_write(5'd4, 32'h3F);  // all aid bits, local 0
    do_req(3'd6, 1'b0, 1'b0, 10'h100, 0, en, evt, rv, rd, evt2);
    check("R3 id6 denied", {31'd0, en}, 0);
    do_req(3'd5, 1'b0, 1'b0, 10'h100, 0, en, evt, rv, rd, evt2);
    check("R3 id5 allowed", {31'd0, en}, 1);
  endtask

  task automatic t_clear_race();
    // record held (id6 from previous), clear on same edge as new violation
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 5'd16; cfg_wdata = 32'h1;
    req_valid = 1'b1; req_id = 3'd7; req_direct = 1'b0; req_we = 1'b1;
    req_addr = 10'h13F; req_wdata = 0;
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    check("R7 race evt", {31'd0, fault_evt}, 1);
    cfg_read(5'd16, r);
    check("R9 race new record", r, stat(1'b1, 3'd7, 10'h13F, 1'b0));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0;
    req_wdata = '0; req_id = '0; req_direct = 1'b0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_open();
    t_deny_all();
    t_local_only();
    t_aid_only();
    t_bad_id();
    t_clear_race();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule